// File: doc/BRIEF.md
# Input-Complete Dual-Rail 2:1 Multiplexer

This block computes a 2:1 multiplexer, `z = sel ? b : a`, where every logical signal travels on a pair of rails: a true rail and a false rail. Asserting exactly one rail carries a value, and leaving both low carries the empty (NULL) token. Values move in waves. Inputs rise from NULL to a value, and later fall back to NULL. The output follows each wave only once the whole input set has completed that wave.

Inside, a plane of threshold gates with hysteresis sits in front of two OR trees. Each gate needs all of its inputs: it sets when every input rail is high, clears when every input rail is low, and otherwise keeps its state. Each gate is modelled as a clocked state element. With the default parameters the plane holds one gate per combination of input values, eight in all, and each gate takes one rail from each of the three inputs. Setting `REDUCED` builds a four-term plane instead. In that plane, the product term that skips the unselected data input still waits on that input through the OR of its two rails. The true output rail merges the terms whose mux result is 1, and the false rail merges the rest. The block works inside a larger dual-rail pipeline that supplies completion detection and handshaking.

Top module: `ncl_mux_dr`

## Requirements
- R1: While `rst` is high on a rising clock edge, every gate clears. After that edge both output rails are low.
- R2: Starting from all-NULL, both output rails stay low while any of the three inputs is still NULL. This includes the data input that `sel` does not pick.
- R3: Once all inputs carry values, the output is the value of `b` when `sel` is 1 and of `a` when `sel` is 0. A 1 is encoded as `z_t=1, z_f=0` and a 0 as `z_t=0, z_f=1`.
- R4: Once the output holds a value, it stays unchanged while any input, selected or not, still carries a value.
- R5: The output returns to NULL on the first rising edge at which all six input rails are low.
- R6: The output takes its value on the first rising edge at which all three inputs carry values. That is a latency of one clock edge after the last rail arrives.
- R7: Given legal inputs (never both rails of one input high), `z_t` and `z_f` are never high together.
- R8: With `REDUCED=1` the block shows the same port behaviour as with the default eight-term plane in every case above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that updates the threshold-gate states |
| rst | input | 1 | Synchronous active-high reset; clears all gates |
| a_f | input | 1 | Data input a, false rail |
| a_t | input | 1 | Data input a, true rail |
| b_f | input | 1 | Data input b, false rail |
| b_t | input | 1 | Data input b, true rail |
| s_f | input | 1 | Select, false rail (picks a) |
| s_t | input | 1 | Select, true rail (picks b) |
| z_f | output | 1 | Result, false rail |
| z_t | output | 1 | Result, true rail |

## Verification
The output rails are a plain OR of gate states, and each gate updates on a rising edge. Every result therefore shows up exactly one rising edge after the rail change that completes a wave, and any earlier partial change must leave the output untouched. The bench changes one rail at a time on a falling edge and reads the outputs on the next falling edge, so each reading reflects exactly one gate update. It applies every arrival and departure order of the three inputs for all eight value combinations, on the default instance and on a reduced-plane instance in parallel.

// File: rtl/ncl_mux_pkg.sv
package ncl_mux_pkg;

    localparam int NUM_IN  = 3;
    localparam int A_IDX   = 0;
    localparam int B_IDX   = 1;
    localparam int SEL_IDX = 2;
    localparam int FULL_TERMS = 1 << NUM_IN;
    localparam int RED_TERMS  = 4;

    typedef struct packed {
        logic t;
        logic f;
    } rail_pair_t;

    typedef rail_pair_t [NUM_IN-1:0] rail_vec_t;

    function automatic int term_count(input bit reduced);
        return reduced ? RED_TERMS : FULL_TERMS;
    endfunction

    // result of the mux for a combination index {sel, b, a}
    function automatic logic mux_truth(input int idx);
        logic [NUM_IN-1:0] v;
        v = NUM_IN'(idx);
        return v[SEL_IDX] ? v[B_IDX] : v[A_IDX];
    endfunction

    function automatic logic rail_of(input rail_pair_t p, input logic v);
        return v ? p.t : p.f;
    endfunction

    function automatic logic any_rail(input rail_pair_t p);
        return p.t | p.f;
    endfunction

endpackage

// File: rtl/ncl_th_gate.sv
module ncl_th_gate #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] in,
    output logic         q
);

    logic state;

    // hysteresis: set on all-high, clear on all-low, otherwise keep
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= 1'b0;
        end else if (&in) begin
            state <= 1'b1;
        end else if (~|in) begin
            state <= 1'b0;
        end
    end

    assign q = state;

endmodule

// File: rtl/ncl_and_plane.sv
module ncl_and_plane
    import ncl_mux_pkg::*;
#(
    parameter bit REDUCED = 1'b0,
    parameter int NT      = term_count(REDUCED)
) (
    input  logic          clk,
    input  logic          rst,
    input  rail_vec_t     ins,
    output logic [NT-1:0] hit,
    output logic [NT-1:0] one
);

    if (!REDUCED) begin : g_canon
        for (genvar i = 0; i < NT; i++) begin : g_term
            logic [NUM_IN-1:0] pick;
            for (genvar j = 0; j < NUM_IN; j++) begin : g_pick
                localparam bit VAL = ((i >> j) & 1) == 1;
                assign pick[j] = rail_of(ins[j], VAL);
            end
            ncl_th_gate #(.N(NUM_IN)) u_gate (
                .clk (clk),
                .rst (rst),
                .in  (pick),
                .q   (hit[i])
            );
            assign one[i] = mux_truth(i);
        end
    end else begin : g_reduced
        for (genvar k = 0; k < NT; k++) begin : g_term
            localparam bit SV   = k >= 2;
            localparam bit DV   = (k % 2) == 1;
            localparam int DIDX = SV ? B_IDX : A_IDX;
            localparam int OIDX = SV ? A_IDX : B_IDX;
            logic [2:0] pick;
            assign pick[0] = rail_of(ins[SEL_IDX], SV);
            assign pick[1] = rail_of(ins[DIDX], DV);
            // completeness term for the unselected data input
            assign pick[2] = any_rail(ins[OIDX]);
            ncl_th_gate #(.N(3)) u_gate (
                .clk (clk),
                .rst (rst),
                .in  (pick),
                .q   (hit[k])
            );
            assign one[k] = DV;
        end
    end

endmodule

// File: rtl/ncl_rail_merge.sv
module ncl_rail_merge
    import ncl_mux_pkg::*;
#(
    parameter int NT = 8
) (
    input  logic [NT-1:0] hit,
    input  logic [NT-1:0] one,
    output rail_pair_t    z
);

    always_comb begin
        z.t = |(hit & one);
        z.f = |(hit & ~one);
    end

endmodule

// File: rtl/ncl_mux_dr.sv
module ncl_mux_dr
    import ncl_mux_pkg::*;
#(
    parameter bit REDUCED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic a_f,
    input  logic a_t,
    input  logic b_f,
    input  logic b_t,
    input  logic s_f,
    input  logic s_t,
    output logic z_f,
    output logic z_t
);

    localparam int NT = term_count(REDUCED);

    rail_vec_t     ins;
    logic [NT-1:0] hit;
    logic [NT-1:0] one;
    rail_pair_t    z;

    assign ins[A_IDX]   = '{t: a_t, f: a_f};
    assign ins[B_IDX]   = '{t: b_t, f: b_f};
    assign ins[SEL_IDX] = '{t: s_t, f: s_f};

    ncl_and_plane #(.REDUCED(REDUCED), .NT(NT)) u_plane (
        .clk (clk),
        .rst (rst),
        .ins (ins),
        .hit (hit),
        .one (one)
    );

    ncl_rail_merge #(.NT(NT)) u_merge (
        .hit (hit),
        .one (one),
        .z   (z)
    );

    assign z_t = z.t;
    assign z_f = z.f;

endmodule

// File: rtl/ncl_mux_dr_chk.sv
module ncl_mux_dr_chk (
    input logic clk,
    input logic rst,
    input logic a_f,
    input logic a_t,
    input logic b_f,
    input logic b_t,
    input logic s_f,
    input logic s_t,
    input logic z_f,
    input logic z_t
);

    logic all_data;
    logic all_null;
    logic z_null;
    logic z_data;
    logic expect_one;

    assign all_data   = (a_f | a_t) & (b_f | b_t) & (s_f | s_t);
    assign all_null   = ~(a_f | a_t | b_f | b_t | s_f | s_t);
    assign z_null     = ~z_f & ~z_t;
    assign z_data     = z_f ^ z_t;
    assign expect_one = s_t ? b_t : a_t;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> z_null);

    assert_waits_for_all_R2: assert property (@(posedge clk) disable iff (rst)
        (z_null && !all_data) |=> z_null);

    assert_mux_value_R3: assert property (@(posedge clk) disable iff (rst)
        all_data |=> (z_t == $past(expect_one)) && (z_f == !$past(expect_one)));

    assert_holds_data_R4: assert property (@(posedge clk) disable iff (rst)
        (z_data && !all_null) |=> $stable({z_f, z_t}));

    assert_returns_null_R5: assert property (@(posedge clk) disable iff (rst)
        (z_data && all_null) |=> z_null);

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (z_null && all_data) |=> z_data);

    assert_rails_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(z_f && z_t));

endmodule

bind ncl_mux_dr ncl_mux_dr_chk i_chk (
    .clk (clk),
    .rst (rst),
    .a_f (a_f),
    .a_t (a_t),
    .b_f (b_f),
    .b_t (b_t),
    .s_f (s_f),
    .s_t (s_t),
    .z_f (z_f),
    .z_t (z_t)
);

// File: tb/test_ncl_mux_dr.sv
`timescale 1ns/1ps
module test_ncl_mux_dr;

    logic       clk;
    logic       rst;
    logic [2:0] rf;   // false rails, index 0=a, 1=b, 2=sel
    logic [2:0] rt;   // true rails
    logic       zf_c, zt_c, zf_r, zt_r;
    int         n_checks;
    int         n_fails;
    bit         done;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    ncl_mux_dr i_ncl_mux_dr (
        .clk (clk), .rst (rst),
        .a_f (rf[0]), .a_t (rt[0]),
        .b_f (rf[1]), .b_t (rt[1]),
        .s_f (rf[2]), .s_t (rt[2]),
        .z_f (zf_c), .z_t (zt_c)
    );

    ncl_mux_dr #(.REDUCED(1'b1)) i_ncl_mux_dr_red (
        .clk (clk), .rst (rst),
        .a_f (rf[0]), .a_t (rt[0]),
        .b_f (rf[1]), .b_t (rt[1]),
        .s_f (rf[2]), .s_t (rt[2]),
        .z_f (zf_r), .z_t (zt_r)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual {z_t,z_f}=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // both instances compared; the reduced one is tagged R8
    task automatic chk_both(input string req, input logic [1:0] exp);
        chk(req, {zt_c, zf_c}, exp);
        chk({req, " R8"}, {zt_r, zf_r}, exp);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    function automatic int perm_at(input int p, input int k);
        case (p)
            0: return k;
            1: return (k == 0) ? 0 : ((k == 1) ? 2 : 1);
            2: return (k == 0) ? 1 : ((k == 1) ? 0 : 2);
            3: return (k == 0) ? 1 : ((k == 1) ? 2 : 0);
            4: return (k == 0) ? 2 : ((k == 1) ? 0 : 1);
            default: return 2 - k;
        endcase
    endfunction

    // R7: rails exclusive, checked every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_checks++;
            if ((zf_c && zt_c) || (zf_r && zt_r)) begin
                n_fails++;
                $display("FAIL R7: both rails high, actual c=%b%b r=%b%b expected not 11",
                         zt_c, zf_c, zt_r, zf_r);
            end
        end
    end

    task automatic t_reset_start();
        rst = 1'b1;
        rf  = 3'b000;
        rt  = 3'b000;
        repeat (3) @(negedge clk);
        chk_both("R1 reset", 2'b00);
        rst = 1'b0;
        @(negedge clk);
        chk_both("R1 after release", 2'b00);
    endtask

    task automatic t_wave(input logic [2:0] val, input int p_on, input int p_off);
        logic [1:0] exp;
        int         idx;
        exp = ((val[2] ? val[1] : val[0]) == 1'b1) ? 2'b10 : 2'b01;
        for (int k = 0; k < 3; k++) begin
            idx = perm_at(p_on, k);
            @(negedge clk);
            rt[idx] = val[idx];
            rf[idx] = ~val[idx];
            @(negedge clk);
            if (k < 2) chk_both("R2 partial arrival", 2'b00);
            else       chk_both("R3 R6 value after last arrival", exp);
        end
        for (int k = 0; k < 3; k++) begin
            idx = perm_at(p_off, k);
            @(negedge clk);
            rt[idx] = 1'b0;
            rf[idx] = 1'b0;
            @(negedge clk);
            if (k < 2) chk_both("R4 partial departure", exp);
            else       chk_both("R5 null after last departure", 2'b00);
        end
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rt = 3'b011;
        rf = 3'b100;
        @(negedge clk);
        chk_both("R3 before mid reset", 2'b10);
        rst = 1'b1;
        @(negedge clk);
        chk_both("R1 mid reset", 2'b00);
        rt  = 3'b000;
        rf  = 3'b000;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_both("R1 null after mid reset", 2'b00);
    endtask

    initial begin
        n_checks = 0;
        n_fails  = 0;
        done     = 1'b0;
        t_reset_start();
        for (int v = 0; v < 8; v++) begin
            for (int p = 0; p < 6; p++) begin
                t_wave(3'(v), p, 5 - p);
            end
        end
        t_reset_mid();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1'b1;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule